// File: doc/BRIEF.md
# Multi-channel compare general-purpose timer

This block is an up-counting peripheral timer that sits on a simple word-addressed register bus. A tick source is picked from two external tick strobes, or none. A programmable divider thins that tick before it reaches the main counter. Three compare channels watch the counter and raise status flags when it lands on their value. Each flag, and a rollover flag, can be routed to one level-sensitive interrupt output through a matching enable bit.

The counter runs in one of two modes. In free-run mode it climbs to all ones, wraps to zero and raises the rollover flag. In restart mode it reloads to zero when it has reached the first compare value. A software reset bit in the control word clears most of the state in one write. It keeps the clock-source and mode bits that are written along with it. An enable-mode bit chooses whether switching the timer back on resumes the held count or starts again from zero.

Top module: `mcmp_timer`

## Requirements
- R1: The word index is `addr_i[5:2]`. Index 0 is control, 1 is divider, 2 is status, 3 is interrupt enable, 4 to 6 are compare 0 to 2, 7 and 8 are unused capture words, and 9 is the counter. Reads of 7, 8, 10 to 15 return zero. Control bits 2, 4, 10 to 15 are not stored and read back as 0. The control layout is: bit 0 enable, bit 1 enable mode, bits [8:6] source, bit 9 free-run.
- R2: Source code 001 or 010 selects `fast_tick_i`. Source code 100 selects `slow_tick_i`. Any other code selects no tick, and the counter holds. While enable is 0 the counter also holds.
- R3: With divider value P (12 bits), the counter advances once per P+1 selected ticks.
- R4: In free-run mode (control bit 9 = 1), a count tick at all ones (2^CNT_W-1) wraps the counter to 0 and sets status bit 5.
- R5: A count tick that brings the counter to compare channel k's value sets status bit k (k = 0..2), whatever the enable bits say. Writing status clears every bit in [5:0] that is written as 1. If a set and a clear hit the same bit in one cycle, the set wins. Status bits 3 and 4 stay 0.
- R6: `irq_o` is 1 exactly when enable is 1 and some status bit is 1 together with the interrupt-enable bit at the same position.
- R7: In restart mode (bit 9 = 0), a count tick while the counter equals compare 0 reloads it to 0 instead of incrementing.
- R8: A control write with bit 15 set stores the written control word with bits [5:0] cleared. It zeroes status, divider, interrupt enable and the counter, and sets all compare words to all ones. Bit 15 reads back 0.
- R9: In restart mode, any write to compare 0 sets the counter to 0 on that clock edge.
- R10: A control write that takes enable from 0 to 1 with bit 1 set restarts the counter at 0. With bit 1 clear, counting resumes from the held value.
- R11: After hardware reset, control, divider, status, interrupt enable and counter read 0, compare words read all ones, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fast_tick_i | input | 1 | Main peripheral tick strobe |
| slow_tick_i | input | 1 | Slow tick strobe |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1 with req_i |
| addr_i | input | ADDR_W | Byte address, word index in [5:2] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions watch a few rules on every clock:
- the counter stays frozen while the timer is off and the bus is quiet;
- a software reset leaves the state it promises;
- a compare-0 write in restart mode zeroes the count;
- the rollover flag only rises in free-run mode;
- the two unused status bits never set.

The divider ratio, source selection, compare-flag timing, the restart reload, and resume versus restart on enable can only be shown by the bench's scenarios. The bench does this by comparing every read and the interrupt line each cycle against its behavioural model.

// File: rtl/mcmp_timer_pkg.sv
package mcmp_timer_pkg;
  localparam int NCH = 3;
  localparam int ST_W = 6;
  localparam int ST_ROV = 5;

  localparam int C_EN = 0;
  localparam int C_ENMOD = 1;
  localparam int C_SRC_LO = 6;
  localparam int C_FREE = 9;
  localparam int C_SWR = 15;

  // stored control bits, and those that survive a software reset
  localparam logic [31:0] CTRL_KEEP = 32'hFFFF_03EB;
  localparam logic [31:0] CTRL_SWR_KEEP = 32'hFFFF_03C0;

  typedef enum logic [3:0] {
    REG_CTRL = 4'd0,
    REG_DIV  = 4'd1,
    REG_STAT = 4'd2,
    REG_IEN  = 4'd3,
    REG_CMP0 = 4'd4,
    REG_CMP1 = 4'd5,
    REG_CMP2 = 4'd6,
    REG_CAP0 = 4'd7,
    REG_CAP1 = 4'd8,
    REG_CNT  = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/mcmp_tick_gen.sv
module mcmp_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [2:0]       src_i,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic src_tick;
  logic last;
  logic [DIV_W-1:0] div_q;

  always_comb begin
    unique case (src_i)
      3'b001, 3'b010: src_tick = fast_tick_i;
      3'b100:         src_tick = slow_tick_i;
      default:        src_tick = 1'b0;
    endcase
  end

  // >= so a divider lowered mid-count still terminates
  assign last   = (div_q >= div_i);
  assign tick_o = run_i && src_tick && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (clr_i)             div_q <= '0;
    else if (run_i && src_tick) div_q <= last ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/mcmp_counter.sv
module mcmp_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             free_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             zero_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o  = (!free_i && cnt_q == lim_i) ? '0 : cnt_q + 1'b1;
  assign wrap_o = tick_i && free_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt_o;
  end
endmodule

// File: rtl/mcmp_match.sv
module mcmp_match #(
  parameter int CNT_W = 32,
  parameter int NCH = 3
) (
  input  logic                      tick_i,
  input  logic [CNT_W-1:0]          val_i,
  input  logic [NCH-1:0][CNT_W-1:0] cmp_i,
  output logic [NCH-1:0]            hit_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign hit_o[k] = tick_i && (val_i == cmp_i[k]);
  end
endmodule

// File: rtl/mcmp_timer.sv
module mcmp_timer
  import mcmp_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 12,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic [31:0]               ctrl_q;
  logic [DIV_W-1:0]          div_q;
  logic [ST_W-1:0]           sr_q;
  logic [ST_W-1:0]           ien_q;
  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]          cnt_q;
  logic [CNT_W-1:0]          cnt_nxt;
  logic [NCH-1:0]            hit;
  logic                      cnt_tick;
  logic                      wrap;
  logic [3:0]                idx;
  logic                      wr, wr_ctrl, swr, en_rise, zero_cnt;
  logic [ST_W-1:0]           st_set, st_clr;

  assign idx     = addr_i[5:2];
  assign wr      = req_i && we_i;
  assign wr_ctrl = wr && idx == REG_CTRL;
  assign swr     = wr_ctrl && wdata_i[C_SWR];
  assign en_rise = wr_ctrl && !swr && wdata_i[C_EN] && !ctrl_q[C_EN];
  assign zero_cnt = swr || (en_rise && wdata_i[C_ENMOD]) ||
                    (wr && idx == REG_CMP0 && !ctrl_q[C_FREE]);

  mcmp_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (ctrl_q[C_EN]),
    .src_i       (ctrl_q[C_SRC_LO+2:C_SRC_LO]),
    .fast_tick_i (fast_tick_i),
    .slow_tick_i (slow_tick_i),
    .div_i       (div_q),
    .clr_i       (swr),
    .tick_o      (cnt_tick)
  );

  mcmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (cnt_tick),
    .free_i (ctrl_q[C_FREE]),
    .lim_i  (cmp_q[0]),
    .zero_i (zero_cnt),
    .cnt_o  (cnt_q),
    .nxt_o  (cnt_nxt),
    .wrap_o (wrap)
  );

  mcmp_match #(.CNT_W(CNT_W), .NCH(NCH)) u_match (
    .tick_i (cnt_tick),
    .val_i  (cnt_nxt),
    .cmp_i  (cmp_q),
    .hit_o  (hit)
  );

  always_comb begin
    st_set = '0;
    st_set[NCH-1:0] = hit;
    st_set[ST_ROV]  = wrap;
    st_clr = (wr && idx == REG_STAT) ? wdata_i[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
      sr_q   <= '0;
      ien_q  <= '0;
    end else if (swr) begin
      ctrl_q <= wdata_i & CTRL_SWR_KEEP;
      div_q  <= '0;
      sr_q   <= '0;
      ien_q  <= '0;
    end else begin
      sr_q <= (sr_q & ~st_clr) | st_set;
      if (wr_ctrl)                 ctrl_q <= wdata_i & CTRL_KEEP;
      if (wr && idx == REG_DIV)    div_q  <= wdata_i[DIV_W-1:0];
      if (wr && idx == REG_IEN)    ien_q  <= wdata_i[ST_W-1:0];
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 cmp_q[k] <= '1;
      else if (swr)                                cmp_q[k] <= '1;
      else if (wr && idx == 4'(int'(REG_CMP0) + k)) cmp_q[k] <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      REG_CTRL: rdata_o = ctrl_q;
      REG_DIV:  rdata_o[DIV_W-1:0] = div_q;
      REG_STAT: rdata_o[ST_W-1:0] = sr_q;
      REG_IEN:  rdata_o[ST_W-1:0] = ien_q;
      REG_CMP0: rdata_o[CNT_W-1:0] = cmp_q[0];
      REG_CMP1: rdata_o[CNT_W-1:0] = cmp_q[1];
      REG_CMP2: rdata_o[CNT_W-1:0] = cmp_q[2];
      REG_CNT:  rdata_o[CNT_W-1:0] = cnt_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = ctrl_q[C_EN] && |(sr_q & ien_q);
endmodule

// File: rtl/mcmp_timer_chk.sv
module mcmp_timer_chk #(
  parameter int CNT_W = 32,
  parameter int ADDR_W = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           ctrl_q,
  input logic [5:0]            sr_q,
  input logic [CNT_W-1:0]      cnt_q,
  input logic [2:0][CNT_W-1:0] cmp_q
);
  logic wr;
  assign wr = req_i && we_i;

  assert_hold_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[0] && !wr) |=> $stable(cnt_q));

  assert_gap_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_q[4:3] == 2'b00);

  assert_rov_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_q[5]) |-> $past(ctrl_q[9]));

  assert_swr_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i[5:2] == 4'd0 && wdata_i[15]) |=>
      (ctrl_q[1:0] == 2'b00 && sr_q == 6'd0 && cnt_q == '0 && (&cmp_q[0])));

  assert_cmp0_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i[5:2] == 4'd4 && !ctrl_q[9]) |=> cnt_q == '0);
endmodule

bind mcmp_timer mcmp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .ctrl_q  (ctrl_q),
  .sr_q    (sr_q),
  .cnt_q   (cnt_q),
  .cmp_q   (cmp_q)
);

// File: tb/mcmp_timer_tb.sv
module mcmp_timer_tb;
  localparam int CW = 8;
  localparam int unsigned MAXC = (1 << CW) - 1;

  logic clk = 0, rst_ni = 0, fast = 0, slow = 0, req = 0, we = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0;
  wire [31:0] rdata;
  wire irq;
  int n_chk = 0, n_bad = 0;
  string tag = "R11";
  bit done = 0;

  always #5 clk = ~clk;

  mcmp_timer #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fast_tick_i(fast), .slow_tick_i(slow),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq));

  // behavioural reference model
  int unsigned m_ctrl, m_div, m_sr, m_ien, m_cnt, m_pc;
  int unsigned m_cmp[3];

  function automatic int unsigned mread(int i);
    case (i)
      0: return m_ctrl;
      1: return m_div;
      2: return m_sr;
      3: return m_ien;
      4, 5, 6: return m_cmp[i-4];
      9: return m_cnt;
      default: return 0;
    endcase
  endfunction

  function automatic bit mirq();
    return (m_ctrl & 1) != 0 && (m_sr & m_ien) != 0;
  endfunction

  task automatic mreset(int unsigned c);
    m_ctrl = c; m_div = 0; m_sr = 0; m_ien = 0; m_cnt = 0; m_pc = 0;
    foreach (m_cmp[i]) m_cmp[i] = MAXC;
  endtask

  task automatic mstep();
    int unsigned s, nc, set, clr;
    bit st, ct, free, en, w;
    int i;
    s = (m_ctrl >> 6) & 7;
    st = (s == 1 || s == 2) ? fast : (s == 4 ? slow : 1'b0);
    en = m_ctrl[0];
    free = m_ctrl[9];
    ct = 0; set = 0; nc = m_cnt;
    if (en && st) begin
      if (m_pc >= m_div) begin m_pc = 0; ct = 1; end else m_pc++;
    end
    if (ct) begin
      if (!free && m_cnt == m_cmp[0]) nc = 0; else nc = (m_cnt + 1) & MAXC;
      if (free && m_cnt == MAXC) set |= 32;
      for (int k = 0; k < 3; k++) if (nc == m_cmp[k]) set |= (1 << k);
    end
    w = req && we;
    i = addr[5:2];
    if (w && i == 0 && wdata[15]) begin
      mreset(wdata & 32'hFFFF_03C0);
    end else begin
      clr = (w && i == 2) ? (wdata & 63) : 0;
      m_sr = (m_sr & ~clr) | set;
      m_cnt = nc;
      if (w) case (i)
        0: begin
          if (wdata[0] && !en && wdata[1]) m_cnt = 0;
          m_ctrl = wdata & 32'hFFFF_03EB;
        end
        1: m_div = wdata & 12'hFFF;
        3: m_ien = wdata & 63;
        4: begin m_cmp[0] = wdata & MAXC; if (!free) m_cnt = 0; end
        5: m_cmp[1] = wdata & MAXC;
        6: m_cmp[2] = wdata & MAXC;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) mreset(0); else mstep();

  task automatic chk(string t, int unsigned act, int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_ni && !done) begin
    chk(tag, rdata, mread(addr[5:2]));
    chk(tag, {31'd0, irq}, {31'd0, mirq()});
  end

  task automatic wr(int i, logic [31:0] v);
    @(posedge clk); #2 req = 1; we = 1; addr = 6'(i << 2); wdata = v;
    @(posedge clk); #2 req = 0; we = 0;
  endtask

  task automatic rd(int i, output int unsigned v);
    @(posedge clk); #2 addr = 6'(i << 2);
    @(negedge clk); v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned v, a, b;
    #23 rst_ni = 1;
    // R11 reset state
    tag = "R11";
    rd(0, v); chk("R11", v, 0);
    rd(4, v); chk("R11", v, MAXC);
    rd(6, v); chk("R11", v, MAXC);
    rd(9, v); chk("R11", v, 0);
    chk("R11", irq, 0);
    // R1 unstored bits and empty words
    tag = "R1";
    wr(0, 32'h0000_FC14); rd(0, v); chk("R1", v, 0);
    wr(7, 32'hFFFF_FFFF); rd(7, v); chk("R1", v, 0);
    rd(12, v); chk("R1", v, 0);
    // R5 compare flags set regardless of interrupt enable, R2 fast source
    tag = "R5";
    wr(4, 5); wr(5, 10); wr(6, 200);
    fast = 1;
    wr(0, 32'h241);
    idle(20);
    rd(2, v); chk("R5", v, 3);
    // R2 no-clock source holds
    tag = "R2";
    wr(0, 32'h2C1);
    rd(9, a); idle(10); rd(9, b); chk("R2", b, a);
    // R3 divider 3: one step per four ticks
    tag = "R3";
    wr(1, 3); wr(0, 32'h241);
    rd(9, a); idle(39); rd(9, b); chk("R3", (b - a) & MAXC, 10);
    // R2 slow source
    tag = "R2";
    wr(1, 0); wr(0, 32'h301);
    rd(9, a); idle(5); rd(9, b); chk("R2", b, a);
    repeat (5) begin @(posedge clk); #2 slow = 1; @(posedge clk); #2 slow = 0; end
    rd(9, b); chk("R2", (b - a) & MAXC, 5);
    // R6 and R5 write-one-to-clear
    tag = "R6";
    wr(2, 6'h3F); wr(3, 3);
    rd(2, v); chk("R5", v, 0); chk("R6", irq, 0);
    wr(4, (b + 2) & MAXC);
    repeat (2) begin @(posedge clk); #2 slow = 1; @(posedge clk); #2 slow = 0; end
    @(negedge clk); chk("R6", irq, 1);
    wr(0, 32'h300); @(negedge clk); chk("R6", irq, 0);
    wr(0, 32'h301); @(negedge clk); chk("R6", irq, 1);
    wr(2, 1); rd(2, v); chk("R5", v, 0); chk("R6", irq, 0);
    // R4 free-run wrap
    tag = "R4";
    wr(3, 6'h20); wr(0, 32'h241);
    idle(300);
    rd(2, v); chk("R4", v & 32'h20, 32'h20); chk("R4", irq, 1);
    // R9 and R7 restart mode
    tag = "R9";
    wr(2, 6'h3F); wr(0, 32'h041);
    wr(4, 20); rd(9, v); chk("R9", v, mread(9));
    tag = "R7";
    a = 0;
    for (int k = 0; k < 60; k++) begin rd(9, v); if (v > a) a = v; end
    chk("R7", a, 20);
    rd(2, v); chk("R7", v & 1, 1);
    // R10 enable mode
    tag = "R10";
    wr(0, 32'h040); rd(9, a); idle(8); rd(9, b); chk("R10", b, a);
    wr(0, 32'h041); rd(9, v); chk("R10", v, mread(9));
    wr(0, 32'h040); wr(0, 32'h043); rd(9, v); chk("R10", v, mread(9));
    // R8 software reset
    tag = "R8";
    wr(1, 7); wr(3, 6'h3F); wr(5, 9);
    wr(0, 32'h8000_8243);
    rd(0, v); chk("R8", v, 32'h8000_0240);
    rd(1, v); chk("R8", v, 0);
    rd(3, v); chk("R8", v, 0);
    rd(5, v); chk("R8", v, MAXC);
    rd(9, v); chk("R8", v, mread(9));
    idle(3);
    finish_run();
  end
endmodule